// File: doc/BRIEF.md
# Late-Write Synchronous SRAM Core

This block is a single-port synchronous static RAM that follows the late-write convention. On a rising clock edge it samples address, chip select, write/read select and per-lane write enables. When that command is a write, its data word is not present yet: the data is taken on the next rising edge. Reads go from a clocked command register to a clocked output register. An asynchronous output enable gates the data-out bus without waiting for a clock edge.

A write that has its data is held in a one-entry pending buffer. The buffer is written into the array on the next edge where the array port is free, which is any edge that carries a write command or no command. A read of an address that matches the pending entry returns the buffered lanes merged over the stored word. A sleep input blocks all new commands and blanks the output. The stored contents are kept, and a buffered write still drains into the array during sleep. The word width is a multiple of 9-bit lanes: 18 bits gives two lanes and 36 bits gives four.

The read side is a stream with no back-pressure. There is no ready signal. A word is presented for exactly the one cycle in which `rd_valid` is high, and the consumer has to accept it then.

Top module: `lw_sram_core`

## Requirements
- R1: While reset is held and right after it is released, `rd_valid` is 0 and `rd_data` is all zeros.
- R2: A read command (`cs`=1, `we`=0, `sleep`=0) sampled at edge N drives `rd_valid`=1 and the word at that address after edge N+1. `rd_valid` stays 1 for that single cycle only.
- R3: For a write command sampled at edge N, the data word is taken from `wr_data` at edge N+1. The value on `wr_data` at edge N has no effect on that write.
- R4: Lane bit i of `lane_we` controls bits [9i+8:9i] of the word. Only enabled lanes are updated. A write with no lanes enabled changes nothing.
- R5: A read of the address held in the pending buffer returns the buffered lanes merged over the array word, lane by lane.
- R6: The pending write is committed on the next edge that carries a write command or no command. It is visible to every later read, both before and after the commit.
- R7: When `oe`=0, `rd_data` is all zeros and `rd_valid` is 0 at once, with no clock edge needed. Raising `oe` again restores the registered output.
- R8: While `sleep`=1, commands are ignored and `rd_data`/`rd_valid` are forced to 0. Stored words are kept. A write whose data arrives at the first sleep edge is still completed.
- R9: In a cycle without a fresh read result, `rd_valid` is 0 and the output register keeps the last read word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset of the control state |
| cs | input | 1 | Chip select; a command is sampled when high |
| we | input | 1 | 1 = write command, 0 = read command |
| lane_we | input | WORD_W/9 | Per-lane write enables, lane i = bits [9i+8:9i] |
| addr | input | $clog2(DEPTH) | Word address |
| wr_data | input | WORD_W | Write data, taken one edge after its command |
| sleep | input | 1 | Low-activity mode: blocks commands and blanks output |
| oe | input | 1 | Asynchronous output enable |
| rd_data | output | WORD_W | Read data, zero when not enabled |
| rd_valid | output | 1 | Read word present this cycle |

## Verification
Read results are due one edge after the command edge. The bench drives every input 2 ns after a rising edge and samples outputs at that same point, so each table row's expected value refers to the read issued in the previous row. Write data is driven in the row after its command, which makes the late-write offset part of each vector. The output-enable and sleep gating are combinational, so those checks change `oe` or `sleep` between edges and sample 1 ns later with no clock edge in between.

// File: rtl/lw_sram_pkg.sv
package lw_sram_pkg;
  localparam int LANE_W = 9;

  typedef enum logic [1:0] {
    CMD_IDLE  = 2'd0,
    CMD_READ  = 2'd1,
    CMD_WRITE = 2'd2
  } cmd_kind_e;
endpackage

// File: rtl/lw_cmd_stage.sv
module lw_cmd_stage
  import lw_sram_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int LANES  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs,
  input  logic              we,
  input  logic              sleep,
  input  logic [ADDR_W-1:0] addr,
  input  logic [LANES-1:0]  lane_we,
  output cmd_kind_e         kind_q,
  output logic [ADDR_W-1:0] addr_q,
  output logic [LANES-1:0]  lanes_q
);
  cmd_kind_e kind_d;

  always_comb begin
    if (!cs || sleep) kind_d = CMD_IDLE;
    else if (we)      kind_d = CMD_WRITE;
    else              kind_d = CMD_READ;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      kind_q  <= CMD_IDLE;
      addr_q  <= '0;
      lanes_q <= '0;
    end else begin
      kind_q  <= kind_d;
      if (kind_d != CMD_IDLE) begin
        addr_q  <= addr;
        lanes_q <= lane_we;
      end
    end
  end
endmodule

// File: rtl/lw_write_buffer.sv
module lw_write_buffer
  import lw_sram_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int WORD_W = 18,
  parameter int LANES  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  cmd_kind_e         kind_q,
  input  logic [ADDR_W-1:0] addr_q,
  input  logic [LANES-1:0]  lanes_q,
  input  logic [WORD_W-1:0] wr_data,
  output logic              pend_valid,
  output logic [ADDR_W-1:0] pend_addr,
  output logic [LANES-1:0]  pend_lanes,
  output logic [WORD_W-1:0] pend_data,
  output logic              commit_en
);
  // The array port is free unless the registered command is a read.
  assign commit_en = pend_valid && (kind_q != CMD_READ);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_valid <= 1'b0;
      pend_addr  <= '0;
      pend_lanes <= '0;
      pend_data  <= '0;
    end else if (kind_q == CMD_WRITE) begin
      pend_valid <= 1'b1;
      pend_addr  <= addr_q;
      pend_lanes <= lanes_q;
      pend_data  <= wr_data;
    end else if (commit_en) begin
      pend_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/lw_sram_array.sv
module lw_sram_array
  import lw_sram_pkg::*;
#(
  parameter int DEPTH  = 64,
  parameter int WORD_W = 18,
  localparam int ADDR_W = $clog2(DEPTH),
  localparam int LANES  = WORD_W / LANE_W
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [LANES-1:0]  wr_lanes,
  input  logic [WORD_W-1:0] wr_word,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [WORD_W-1:0] rd_word
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
      if (wr_en && wr_lanes[g])
        cells[wr_addr] <= wr_word[g*LANE_W +: LANE_W];
    end

    assign rd_word[g*LANE_W +: LANE_W] = cells[rd_addr];
  end
endmodule

// File: rtl/lw_read_merge.sv
module lw_read_merge
  import lw_sram_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int WORD_W = 18,
  parameter int LANES  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_fire,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic [WORD_W-1:0] array_word,
  input  logic              pend_valid,
  input  logic [ADDR_W-1:0] pend_addr,
  input  logic [LANES-1:0]  pend_lanes,
  input  logic [WORD_W-1:0] pend_data,
  output logic [WORD_W-1:0] dout_q,
  output logic              dvalid_q
);
  logic              hit;
  logic [WORD_W-1:0] merged;

  assign hit = pend_valid && (pend_addr == rd_addr);

  for (genvar g = 0; g < LANES; g++) begin : g_mix
    assign merged[g*LANE_W +: LANE_W] = (hit && pend_lanes[g])
                                      ? pend_data[g*LANE_W +: LANE_W]
                                      : array_word[g*LANE_W +: LANE_W];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dout_q   <= '0;
      dvalid_q <= 1'b0;
    end else begin
      dvalid_q <= rd_fire;
      if (rd_fire) dout_q <= merged;
    end
  end
endmodule

// File: rtl/lw_sram_core.sv
module lw_sram_core
  import lw_sram_pkg::*;
#(
  parameter int WORD_W = 18,
  parameter int DEPTH  = 64,
  localparam int ADDR_W = $clog2(DEPTH),
  localparam int LANES  = WORD_W / LANE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs,
  input  logic              we,
  input  logic [LANES-1:0]  lane_we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [WORD_W-1:0] wr_data,
  input  logic              sleep,
  input  logic              oe,
  output logic [WORD_W-1:0] rd_data,
  output logic              rd_valid
);
  cmd_kind_e         cmd_kind_q;
  logic [ADDR_W-1:0] cmd_addr_q;
  logic [LANES-1:0]  cmd_lanes_q;
  logic              pend_valid;
  logic [ADDR_W-1:0] pend_addr;
  logic [LANES-1:0]  pend_lanes;
  logic [WORD_W-1:0] pend_data;
  logic              commit_en;
  logic [WORD_W-1:0] array_word;
  logic [WORD_W-1:0] dout_q;
  logic              dvalid_q;
  logic              drive_en;

  lw_cmd_stage #(.ADDR_W(ADDR_W), .LANES(LANES)) u_cmd (
    .clk(clk), .rst_n(rst_n), .cs(cs), .we(we), .sleep(sleep),
    .addr(addr), .lane_we(lane_we),
    .kind_q(cmd_kind_q), .addr_q(cmd_addr_q), .lanes_q(cmd_lanes_q)
  );

  lw_write_buffer #(.ADDR_W(ADDR_W), .WORD_W(WORD_W), .LANES(LANES)) u_wbuf (
    .clk(clk), .rst_n(rst_n), .kind_q(cmd_kind_q), .addr_q(cmd_addr_q),
    .lanes_q(cmd_lanes_q), .wr_data(wr_data),
    .pend_valid(pend_valid), .pend_addr(pend_addr), .pend_lanes(pend_lanes),
    .pend_data(pend_data), .commit_en(commit_en)
  );

  lw_sram_array #(.DEPTH(DEPTH), .WORD_W(WORD_W)) u_array (
    .clk(clk), .wr_en(commit_en), .wr_addr(pend_addr), .wr_lanes(pend_lanes),
    .wr_word(pend_data), .rd_addr(cmd_addr_q), .rd_word(array_word)
  );

  lw_read_merge #(.ADDR_W(ADDR_W), .WORD_W(WORD_W), .LANES(LANES)) u_rmerge (
    .clk(clk), .rst_n(rst_n), .rd_fire(cmd_kind_q == CMD_READ),
    .rd_addr(cmd_addr_q), .array_word(array_word),
    .pend_valid(pend_valid), .pend_addr(pend_addr), .pend_lanes(pend_lanes),
    .pend_data(pend_data), .dout_q(dout_q), .dvalid_q(dvalid_q)
  );

  // Output gating is combinational: no clock edge between oe/sleep and the bus.
  assign drive_en = oe && !sleep;
  assign rd_data  = drive_en ? dout_q : '0;
  assign rd_valid = drive_en && dvalid_q;
endmodule

// File: rtl/lw_sram_core_chk.sv
module lw_sram_core_chk
  import lw_sram_pkg::*;
#(
  parameter int WORD_W = 18
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cs,
  input logic              we,
  input logic              sleep,
  input logic              oe,
  input logic [WORD_W-1:0] rd_data,
  input logic              rd_valid,
  input cmd_kind_e         cmd_kind,
  input logic              pend_valid,
  input logic              dvalid
);
  a_r2_read_latency: assert property (@(posedge clk) disable iff (!rst_n)
    (cs && !we && !sleep) |=> ##1 dvalid);

  a_r9_no_stale_valid: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_kind != CMD_READ) |=> !dvalid);

  a_r3_write_fills_buffer: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_kind == CMD_WRITE) |=> pend_valid);

  a_r6_idle_commits: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_valid && cmd_kind == CMD_IDLE) |=> !pend_valid);

  a_r8_sleep_blocks_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    sleep |=> (cmd_kind == CMD_IDLE));

  a_r8_sleep_drains: assert property (@(posedge clk) disable iff (!rst_n)
    (sleep && $past(sleep)) |=> !pend_valid);

  a_r7_oe_blanks: assert property (@(posedge clk) disable iff (!rst_n)
    !oe |-> (rd_data == '0 && !rd_valid));
endmodule

bind lw_sram_core lw_sram_core_chk #(.WORD_W(WORD_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs(cs), .we(we), .sleep(sleep), .oe(oe),
  .rd_data(rd_data), .rd_valid(rd_valid), .cmd_kind(cmd_kind_q),
  .pend_valid(pend_valid), .dvalid(dvalid_q)
);

// File: tb/sim_lw_sram_core.sv
module sim_lw_sram_core;
  localparam int WORD_W = 18;
  localparam int DEPTH  = 64;
  localparam int ADDR_W = 6;
  localparam int LANES  = 2;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              cs = 1'b0, we = 1'b0, sleep = 1'b0, oe = 1'b1;
  logic [LANES-1:0]  lane_we = '0;
  logic [ADDR_W-1:0] addr = '0;
  logic [WORD_W-1:0] wr_data = '0;
  logic [WORD_W-1:0] rd_data;
  logic              rd_valid;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  lw_sram_core #(.WORD_W(WORD_W), .DEPTH(DEPTH)) u0 (
    .clk(clk), .rst_n(rst_n), .cs(cs), .we(we), .lane_we(lane_we),
    .addr(addr), .wr_data(wr_data), .sleep(sleep), .oe(oe),
    .rd_data(rd_data), .rd_valid(rd_valid)
  );

  typedef struct packed {
    logic              cs;
    logic              we;
    logic [LANES-1:0]  lanes;
    logic [ADDR_W-1:0] addr;
    logic [WORD_W-1:0] wdata;   // data word belonging to the previous row's write
    logic              exp_v;
    logic [WORD_W-1:0] exp_d;
    logic [2:0]        tag;     // 0:R9 1:R2 2:R3 3:R5 4:R4 5:R6
  } vec_t;

  localparam int NV = 20;
  localparam vec_t VEC [NV] = '{
    '{1'b1, 1'b1, 2'b11, 6'd5, 18'h3FFFF, 1'b0, 18'h00000, 3'd2},
    '{1'b1, 1'b1, 2'b11, 6'd9, 18'h12345, 1'b0, 18'h00000, 3'd0},
    '{1'b1, 1'b0, 2'b00, 6'd5, 18'h0ABCD, 1'b0, 18'h00000, 3'd0},
    '{1'b1, 1'b0, 2'b00, 6'd9, 18'h00000, 1'b1, 18'h12345, 3'd2},
    '{1'b0, 1'b0, 2'b00, 6'd0, 18'h00000, 1'b1, 18'h0ABCD, 3'd3},
    '{1'b1, 1'b1, 2'b01, 6'd5, 18'h00000, 1'b0, 18'h00000, 3'd0},
    '{1'b1, 1'b0, 2'b00, 6'd5, 18'h3FFFF, 1'b0, 18'h00000, 3'd0},
    '{1'b0, 1'b0, 2'b00, 6'd0, 18'h00000, 1'b1, 18'h123FF, 3'd3},
    '{1'b1, 1'b0, 2'b00, 6'd5, 18'h00000, 1'b0, 18'h00000, 3'd0},
    '{1'b0, 1'b0, 2'b00, 6'd0, 18'h00000, 1'b1, 18'h123FF, 3'd5},
    '{1'b1, 1'b1, 2'b10, 6'd5, 18'h00000, 1'b0, 18'h00000, 3'd0},
    '{1'b1, 1'b0, 2'b00, 6'd5, 18'h00000, 1'b0, 18'h00000, 3'd0},
    '{1'b0, 1'b0, 2'b00, 6'd0, 18'h00000, 1'b1, 18'h001FF, 3'd3},
    '{1'b0, 1'b0, 2'b00, 6'd0, 18'h00000, 1'b0, 18'h00000, 3'd0},
    '{1'b1, 1'b0, 2'b00, 6'd5, 18'h00000, 1'b0, 18'h00000, 3'd0},
    '{1'b0, 1'b0, 2'b00, 6'd0, 18'h00000, 1'b1, 18'h001FF, 3'd5},
    '{1'b1, 1'b1, 2'b00, 6'd5, 18'h00000, 1'b0, 18'h00000, 3'd0},
    '{1'b0, 1'b0, 2'b00, 6'd0, 18'h3FFFF, 1'b0, 18'h00000, 3'd0},
    '{1'b1, 1'b0, 2'b00, 6'd5, 18'h00000, 1'b0, 18'h00000, 3'd0},
    '{1'b0, 1'b0, 2'b00, 6'd0, 18'h00000, 1'b1, 18'h001FF, 3'd4}
  };

  function automatic string tag_name(input logic [2:0] t);
    case (t)
      3'd1: return "R2";
      3'd2: return "R3";
      3'd3: return "R5";
      3'd4: return "R4";
      3'd5: return "R6";
      default: return "R9";
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [WORD_W:0] act, input logic [WORD_W:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // Drive one cycle's inputs, take the edge, settle 2 ns past it.
  task automatic cyc(input logic c, input logic w, input logic [LANES-1:0] ln,
                     input logic [ADDR_W-1:0] a, input logic [WORD_W-1:0] d,
                     input logic slp);
    cs = c; we = w; lane_we = ln; addr = a; wr_data = d; sleep = slp;
    @(posedge clk);
    #2;
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog (all requirements): actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    repeat (3) @(posedge clk);
    #2;
    check(rd_valid == 1'b0 && rd_data == '0, "R1", "during reset",
          {rd_valid, rd_data}, '0);
    rst_n = 1'b1;
    cyc(0, 0, 2'b00, '0, '0, 0);
    check(rd_valid == 1'b0 && rd_data == '0, "R1", "after reset",
          {rd_valid, rd_data}, '0);

    // Vector table: R2 R3 R4 R5 R6 R9
    for (int k = 0; k < NV; k++) begin
      cyc(VEC[k].cs, VEC[k].we, VEC[k].lanes, VEC[k].addr, VEC[k].wdata, 1'b0);
      if (VEC[k].exp_v)
        check(rd_valid == 1'b1 && rd_data == VEC[k].exp_d,
              {"R2 ", tag_name(VEC[k].tag)}, $sformatf("vector %0d", k),
              {rd_valid, rd_data}, {1'b1, VEC[k].exp_d});
      else
        check(rd_valid == 1'b0, "R9", $sformatf("vector %0d valid", k),
              {WORD_W'(0), rd_valid}, '0);
    end

    // R9: idle cycle keeps the last word, valid drops
    cyc(0, 0, 2'b00, '0, '0, 0);
    check(rd_valid == 1'b0 && rd_data == 18'h001FF, "R9", "hold after idle",
          {rd_valid, rd_data}, {1'b0, 18'h001FF});

    // R7: asynchronous output enable
    cyc(1, 0, 2'b00, 6'd5, '0, 0);
    cyc(0, 0, 2'b00, '0, '0, 0);
    check(rd_valid == 1'b1 && rd_data == 18'h001FF, "R2", "read before oe test",
          {rd_valid, rd_data}, {1'b1, 18'h001FF});
    oe = 1'b0;
    #1;
    check(rd_valid == 1'b0 && rd_data == '0, "R7", "oe low blanks",
          {rd_valid, rd_data}, '0);
    oe = 1'b1;
    #1;
    check(rd_valid == 1'b1 && rd_data == 18'h001FF, "R7", "oe high restores",
          {rd_valid, rd_data}, {1'b1, 18'h001FF});

    // R8: sleep
    cyc(1, 1, 2'b11, 6'd5, '0, 0);
    cyc(1, 1, 2'b11, 6'd5, 18'h15555, 1);   // write data lands at first sleep edge; new write ignored
    check(rd_valid == 1'b0 && rd_data == '0, "R8", "output blank in sleep",
          {rd_valid, rd_data}, '0);
    cyc(1, 0, 2'b00, 6'd5, 18'h00000, 1);   // read ignored; data for ignored write
    cyc(0, 0, 2'b00, '0, 18'h2AAAA, 0);
    check(rd_valid == 1'b0, "R8", "read during sleep ignored",
          {WORD_W'(0), rd_valid}, '0);
    cyc(1, 0, 2'b00, 6'd5, '0, 0);
    cyc(0, 0, 2'b00, '0, '0, 0);
    check(rd_valid == 1'b1 && rd_data == 18'h15555, "R8", "contents after sleep",
          {rd_valid, rd_data}, {1'b1, 18'h15555});

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule